// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Transceiver

This block is an 8-bit, full-duplex, clock-synchronous serial channel that always acts as the master. A byte written into the transmit holding buffer is moved into a shift register. The block then generates eight transfer-clock pulses from an internal baud generator. On each pulse it shifts one bit out on `sdo` and samples one bit from `sdi`. The assembled byte lands in a receive buffer, where it waits until it is read.

Static configuration inputs set the behaviour of the channel:
- the prescaler source and divider of the baud generator;
- the transfer-clock polarity;
- the bit order;
- optional inversion of the data logic;
- independent transmit and receive enables;
- a flow-control choice between a clear-to-send input that gates transmission and a ready-to-receive output that advertises space.

Status outputs show whether the transmit buffer and the shift register are empty and whether a received byte is waiting. A one-cycle transmit interrupt fires either when the buffer hands its byte to the shift register or when a transmission has fully finished. A continuous-receive option starts transfers on its own, sending all-ones filler, whenever the receive buffer is free and no real data is pending.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, the transmit-buffer-empty and shift-empty flags are 1, the receive-full flag is 0, `sclk` sits at the level of `cfg_clk_pol`, and `rts` is 1.
- R2: Each half period of `sclk` lasts P*(`cfg_brg_div`+1) clock cycles. P depends on `cfg_src_sel`: P=1 for 2'b00, P=8 for 2'b01 and P=32 for 2'b10. The value 2'b11 is not used.
- R3: With `cfg_clk_pol`=0, `sclk` idles low, `sdo` changes on falling edges and `sdi` is sampled on rising edges. With `cfg_clk_pol`=1 the clock idles high and both edges swap roles. Each byte produces exactly 8 leading edges.
- R4: With `cfg_msb_first`=0, bit 0 of a byte is the first bit on the wire in both directions. With `cfg_msb_first`=1, bit 7 goes first.
- R5: With `cfg_invert`=1, every bit sent on `sdo` and every bit taken from `sdi` is complemented. With `cfg_invert`=0, data passes unchanged.
- R6: A write makes the transmit-buffer-empty flag 0 from the next cycle. One cycle later, if transmission is allowed, the byte moves to the shift register: the buffer-empty flag returns to 1 and the shift-empty flag drops to 0 until the last clock edge.
- R7: When a transfer ends with receive enabled, the byte appears on `rx_data` and the receive-full flag becomes 1. A `rx_rd` pulse clears the flag.
- R8: With `cfg_irq_on_done`=0, `tx_irq` pulses once per byte when the byte leaves the buffer, while the shift register is busy. With `cfg_irq_on_done`=1, it pulses once after the shift register has emptied.
- R9: With `cfg_tx_en`=0, a written byte stays in the buffer and no transfer starts. With `cfg_rx_en`=0, a completed transfer leaves the receive-full flag at 0.
- R10: With `cfg_hs_off`=0 and `cfg_hs_rts`=0, no byte leaves the transmit buffer while `cts` is 1. Transmission resumes when `cts` goes to 0.
- R11: With `cfg_hs_off`=0 and `cfg_hs_rts`=1, `rts` is 0 only while receive is enabled and the receive buffer is empty. In every other configuration, `rts` is 1.
- R12: With `cfg_cont_rx`=1 and receive enabled, a transfer that sends all-ones starts by itself whenever the transmit buffer and receive buffer are both empty. This needs neither a transmit write nor the transmit enable.
- R13: `sdo` is 1 whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_src_sel | input | 2 | Baud prescaler source: 00 /1, 01 /8, 10 /32 |
| cfg_brg_div | input | 8 | Half-period divider minus one |
| cfg_clk_pol | input | 1 | Transfer-clock idle level and edge selection |
| cfg_msb_first | input | 1 | 1 selects MSB-first shifting |
| cfg_invert | input | 1 | 1 inverts data in both directions |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_hs_off | input | 1 | 1 bypasses flow control |
| cfg_hs_rts | input | 1 | Flow-control mode: 0 clear-to-send input, 1 ready output |
| cfg_irq_on_done | input | 1 | Interrupt cause: 0 buffer empty, 1 shift done |
| cfg_cont_rx | input | 1 | Continuous receive enable |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe that clears the receive-full flag |
| rx_data | output | 8 | Receive buffer contents |
| flag_tx_buf_empty | output | 1 | Transmit buffer holds no byte |
| flag_tx_shift_empty | output | 1 | Shift register idle |
| flag_rx_full | output | 1 | Received byte waiting |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| sclk | output | 1 | Transfer clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cts | input | 1 | Clear-to-send; 1 blocks transmission |
| rts | output | 1 | Ready-to-receive; 0 means space available |

## Verification
The assertions assume that every `cfg_*` input, `cfg_brg_div` included, stays constant while the shift register is busy. They also assume that `cfg_src_sel` never takes the unused code and that `cts` is always at a known level. The bench keeps within these assumptions. It reprograms configuration only after the shift-empty flag has been seen high and the monitor has been re-armed. It drives `cts` to a defined value from reset onwards and uses only the three legal prescaler codes. A slave model in the bench watches `sclk` edges, so the data checks hold for any divider setting.

// File: rtl/sync_serial_pkg.sv
// Package: shared types and helpers for the synchronous serial master.
// Assumes: the prescaler code 2'b11 is never programmed. If it is, it is treated like /32.
package sync_serial_pkg;

    localparam int PRE_W = 5;

    typedef enum logic [1:0] {
        SRC_DIV1  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_RSVD  = 2'b11
    } src_sel_e;

    // Returns the terminal count of the prescaler for a source code.
    function automatic logic [PRE_W-1:0] presc_last(input src_sel_e s);
        case (s)
            SRC_DIV1: presc_last = PRE_W'(0);
            SRC_DIV8: presc_last = PRE_W'(7);
            default:  presc_last = PRE_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/ssm_baud.sv
// Module: baud generator. It produces one half_tick per half period of the transfer clock.
// Assumes: src_sel and div stay stable while run is high. The counters clear while run is low,
// so the first tick comes a full half period after run rises.
module ssm_baud
    import sync_serial_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_wrap;

    assign pre_lim   = presc_last(src_sel_e'(src_sel));
    assign pre_wrap  = (pre_cnt == pre_lim);
    assign half_tick = run && pre_wrap && (div_cnt == div);

    // Purpose: advance the prescaler, then the divider, while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= (div_cnt == div) ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    a_r2_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_cnt <= div));
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt <= pre_lim));

endmodule

// File: rtl/ssm_codec.sv
// Module: bit-order and logic-inversion codec. It is purely combinational.
// tx_word is laid out so that bit 0 goes onto the wire first. rx_wire holds the first received bit in bit 0.
module ssm_codec #(
    parameter int W = 8
) (
    input  logic         msb_first,
    input  logic         invert,
    input  logic [W-1:0] tx_byte,
    output logic [W-1:0] tx_word,
    input  logic [W-1:0] rx_wire,
    output logic [W-1:0] rx_byte
);

    logic [W-1:0] tx_rev;
    logic [W-1:0] rx_rev;

    // Purpose: build the bit-reversed copies of both directions.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign tx_rev[i] = tx_byte[W-1-i];
        assign rx_rev[i] = rx_wire[W-1-i];
    end

    assign tx_word = (msb_first ? tx_rev : tx_byte) ^ {W{invert}};
    assign rx_byte = (msb_first ? rx_rev : rx_wire) ^ {W{invert}};

endmodule

// File: rtl/ssm_shifter.sv
// Module: shift engine. Each half_tick toggles the raw transfer clock, which idles at 0.
// The leading edge samples sdi and the trailing edge moves to the next output bit.
// After 2*W half periods, done pulses for one cycle.
// Assumes: start is ignored while busy.
module ssm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_word,
    input  logic         half_tick,
    input  logic         sdi,
    output logic         busy,
    output logic         sclk_raw,
    output logic         sdo_bit,
    output logic         done,
    output logic [W-1:0] rx_wire
);

    localparam int CNT_W = $clog2(2 * W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * W - 1);

    logic [CNT_W-1:0] edge_cnt;
    logic [W-1:0]     tx_sr;
    logic [W-1:0]     rx_sr;

    assign sdo_bit = tx_sr[0];
    assign rx_wire = rx_sr;

    // Purpose: run the transfer sequence from start to the final trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            sclk_raw <= 1'b0;
            edge_cnt <= '0;
            tx_sr    <= '1;
            rx_sr    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy     <= 1'b1;
                sclk_raw <= 1'b0;
                edge_cnt <= '0;
                tx_sr    <= tx_word;
            end else if (busy && half_tick) begin
                sclk_raw <= ~sclk_raw;
                edge_cnt <= edge_cnt + 1'b1;
                if (!sclk_raw) begin
                    rx_sr <= {sdi, rx_sr[W-1:1]};
                end else begin
                    tx_sr <= {1'b1, tx_sr[W-1:1]};
                end
                if (edge_cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    a_r3_raw_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk_raw);
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sync_serial_master.sv
// Module: top of the clock-synchronous serial master transceiver.
// It holds the transmit buffer and receive buffer, decides when a transfer starts
// (normal or continuous receive), applies flow control and forms the interrupt.
// Assumes: the cfg_* inputs change only while flag_tx_shift_empty is 1.
module sync_serial_master #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_src_sel,
    input  logic [DIV_W-1:0]  cfg_brg_div,
    input  logic              cfg_clk_pol,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_hs_off,
    input  logic              cfg_hs_rts,
    input  logic              cfg_irq_on_done,
    input  logic              cfg_cont_rx,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              flag_tx_buf_empty,
    output logic              flag_tx_shift_empty,
    output logic              flag_rx_full,
    output logic              tx_irq,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    input  logic              cts,
    output logic              rts
);

    logic [DATA_W-1:0] tb_data;
    logic              tb_full;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_full;
    logic              real_xfer;

    logic              eng_busy;
    logic              eng_done;
    logic              eng_raw;
    logic              eng_sdo;
    logic [DATA_W-1:0] eng_rx_wire;
    logic              half_tick;

    logic [DATA_W-1:0] enc_word;
    logic [DATA_W-1:0] dec_byte;
    logic [DATA_W-1:0] word_in;

    logic              cts_mode;
    logic              rts_mode;
    logic              tx_go;
    logic              cr_go;
    logic              start;
    logic              load;

    // Purpose: decode the flow-control mode.
    assign cts_mode = !cfg_hs_off && !cfg_hs_rts;
    assign rts_mode = !cfg_hs_off &&  cfg_hs_rts;

    // Purpose: decide whether a real byte or a filler byte may start a transfer.
    always_comb begin
        tx_go = cfg_tx_en && tb_full && !(cts_mode && cts);
        cr_go = cfg_rx_en && cfg_cont_rx && !tb_full && !rx_full;
        start = !eng_busy && !eng_done && (tx_go || cr_go);
        load  = start && tx_go;
        word_in = tx_go ? enc_word : {DATA_W{1'b1}};
    end

    ssm_codec #(.W(DATA_W)) u_codec (
        .msb_first (cfg_msb_first),
        .invert    (cfg_invert),
        .tx_byte   (tb_data),
        .tx_word   (enc_word),
        .rx_wire   (eng_rx_wire),
        .rx_byte   (dec_byte)
    );

    ssm_baud #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .src_sel   (cfg_src_sel),
        .div       (cfg_brg_div),
        .half_tick (half_tick)
    );

    ssm_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_word   (word_in),
        .half_tick (half_tick),
        .sdi       (sdi),
        .busy      (eng_busy),
        .sclk_raw  (eng_raw),
        .sdo_bit   (eng_sdo),
        .done      (eng_done),
        .rx_wire   (eng_rx_wire)
    );

    // Purpose: maintain the transmit holding buffer. A write in the load cycle refills it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_full <= 1'b0;
            tb_data <= '0;
        end else if (tx_wr) begin
            tb_full <= 1'b1;
            tb_data <= tx_data;
        end else if (load) begin
            tb_full <= 1'b0;
        end
    end

    // Purpose: remember whether the running transfer carries real transmit data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            real_xfer <= 1'b0;
        end else if (start) begin
            real_xfer <= tx_go;
        end
    end

    // Purpose: capture the received byte and clear the full flag on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (eng_done && cfg_rx_en) begin
            rx_buf  <= dec_byte;
            rx_full <= 1'b1;
        end else if (rx_rd) begin
            rx_full <= 1'b0;
        end
    end

    // Purpose: generate the one-cycle transmit interrupt from the selected cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq <= 1'b0;
        end else begin
            tx_irq <= cfg_irq_on_done ? (eng_done && real_xfer) : load;
        end
    end

    assign rx_data             = rx_buf;
    assign flag_tx_buf_empty   = !tb_full;
    assign flag_tx_shift_empty = !eng_busy;
    assign flag_rx_full        = rx_full;
    assign sclk                = eng_raw ^ cfg_clk_pol;
    assign sdo                 = eng_busy ? eng_sdo : 1'b1;
    assign rts                 = rts_mode ? !(cfg_rx_en && !rx_full) : 1'b1;

    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (sclk == cfg_clk_pol));
    a_r6_buffer_to_shifter: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tb_full) |-> eng_busy);
    a_r7_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(eng_done));
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);
    a_r10_cts_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_mode && cts && !cfg_cont_rx && !eng_busy) |=> !eng_busy);
    a_r11_rts_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_mode && rx_full) |-> rts);
    a_r13_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> sdo);

endmodule

// File: tb/tb_sync_serial_master.sv
module tb_sync_serial_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_src_sel = 2'b00;
    logic [7:0] cfg_brg_div = 8'd1;
    logic       cfg_clk_pol = 1'b0, cfg_msb_first = 1'b0, cfg_invert = 1'b0;
    logic       cfg_tx_en = 1'b1, cfg_rx_en = 1'b1, cfg_hs_off = 1'b1, cfg_hs_rts = 1'b0;
    logic       cfg_irq_on_done = 1'b0, cfg_cont_rx = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       flag_tx_buf_empty, flag_tx_shift_empty, flag_rx_full, tx_irq;
    logic       sclk, sdo;
    logic       sdi = 1'b1, cts = 1'b0;
    logic       rts;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int lead_cnt = 0, trail_cnt = 0, last_edge = 0, last_half = 0;
    int irq_cnt = 0;
    logic irq_se = 1'b0;
    logic [7:0] cap = 8'h00;
    logic [7:0] s_wire = 8'h00;
    logic sclk_q = 1'b0;

    sync_serial_master dut (.*);

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    // Slave model: capture sdo on leading edges and present sdi after trailing edges.
    always @(negedge clk) begin
        if (sclk !== sclk_q) begin
            if (sclk != cfg_clk_pol) begin
                if (lead_cnt < 8) cap[lead_cnt] = sdo;
                lead_cnt++;
            end else begin
                trail_cnt++;
                if (trail_cnt < 8) sdi = s_wire[trail_cnt];
            end
            last_half = cyc - last_edge;
            last_edge = cyc;
        end
        sclk_q = sclk;
        if (tx_irq) begin
            irq_cnt++;
            irq_se = flag_tx_shift_empty;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [7:0] d, input logic m, input logic v);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = (m ? d[7-k] : d[k]) ^ v;
        return r;
    endfunction

    function automatic logic [7:0] dec(input logic [7:0] w, input logic m, input logic v);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[j] = (m ? w[7-j] : w[j]) ^ v;
        return r;
    endfunction

    task automatic arm(input logic [7:0] w);
        @(negedge clk); #1;
        s_wire = w; lead_cnt = 0; trail_cnt = 0; cap = 8'h00; irq_cnt = 0;
        sdi = w[0];
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (flag_tx_shift_empty && t < 200) begin @(negedge clk); t++; end
        t = 0;
        while (!flag_tx_shift_empty && t < 20000) begin @(negedge clk); t++; end
        if (t >= 20000) chk(1'b0, "timeout", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); tx_data = d; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_byte();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk(flag_tx_buf_empty == 1'b1, "R1 buf empty", flag_tx_buf_empty, 1);
        chk(flag_tx_shift_empty == 1'b1, "R1 shift empty", flag_tx_shift_empty, 1);
        chk(flag_rx_full == 1'b0, "R1 rx full", flag_rx_full, 0);
        chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
        chk(rts == 1'b1, "R1 rts", rts, 1);
        chk(sdo == 1'b1, "R13 sdo idle", sdo, 1);
    endtask

    task automatic t_flags();
        arm(8'h5A);
        @(negedge clk); tx_data = 8'hC3; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        chk(flag_tx_buf_empty == 1'b0, "R6 buf full after write", flag_tx_buf_empty, 0);
        chk(flag_tx_shift_empty == 1'b1, "R6 shift idle before load", flag_tx_shift_empty, 1);
        @(negedge clk);
        chk(flag_tx_buf_empty == 1'b1, "R6 buf empty after load", flag_tx_buf_empty, 1);
        chk(flag_tx_shift_empty == 1'b0, "R6 shift busy after load", flag_tx_shift_empty, 0);
        wait_idle();
        chk(cap == 8'hC3, "R6 sent byte", cap, 8'hC3);
        chk(flag_rx_full == 1'b1, "R7 rx full set", flag_rx_full, 1);
        chk(rx_data == 8'h5A, "R7 rx data", rx_data, 8'h5A);
        chk(sdo == 1'b1, "R13 sdo idle after transfer", sdo, 1);
        read_byte();
        chk(flag_rx_full == 1'b0, "R7 rx full cleared", flag_rx_full, 0);
    endtask

    task automatic t_prescaler();
        logic [1:0] sel [3] = '{2'b00, 2'b01, 2'b10};
        int pv [3] = '{1, 8, 32};
        int dv [3] = '{3, 2, 0};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); cfg_src_sel = sel[i]; cfg_brg_div = 8'(dv[i]);
            arm(8'h00);
            write_byte(8'h96);
            wait_idle();
            chk(last_half == pv[i] * (dv[i] + 1), "R2 half period", last_half, pv[i] * (dv[i] + 1));
            read_byte();
        end
        @(negedge clk); cfg_src_sel = 2'b00; cfg_brg_div = 8'd1;
    endtask

    task automatic t_modes();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] d, w;
            d = 8'h3C + 8'(i * 37);
            w = 8'hC5 ^ 8'(i * 29);
            @(negedge clk);
            cfg_clk_pol = i[0]; cfg_msb_first = i[1]; cfg_invert = i[2];
            arm(w);
            chk(sclk == cfg_clk_pol, "R3 idle level", sclk, cfg_clk_pol);
            write_byte(d);
            wait_idle();
            chk(lead_cnt == 8, "R3 leading edges", lead_cnt, 8);
            chk(cap == enc(d, i[1], i[2]), "R4/R5 tx wire", cap, enc(d, i[1], i[2]));
            chk(rx_data == dec(w, i[1], i[2]), "R4/R5 rx byte", rx_data, dec(w, i[1], i[2]));
            read_byte();
        end
        @(negedge clk); cfg_clk_pol = 1'b0; cfg_msb_first = 1'b0; cfg_invert = 1'b0;
    endtask

    task automatic t_irq();
        for (int c = 0; c < 2; c++) begin
            @(negedge clk); cfg_irq_on_done = c[0];
            arm(8'h11);
            write_byte(8'h22);
            wait_idle();
            chk(irq_cnt == 1, "R8 irq count", irq_cnt, 1);
            chk(irq_se == c[0], "R8 irq cause", irq_se, c);
            read_byte();
        end
        @(negedge clk); cfg_irq_on_done = 1'b0;
    endtask

    task automatic t_enables();
        @(negedge clk); cfg_tx_en = 1'b0;
        arm(8'h0F);
        write_byte(8'h81);
        repeat (60) @(negedge clk);
        chk(flag_tx_buf_empty == 1'b0, "R9 tx disabled holds byte", flag_tx_buf_empty, 0);
        chk(flag_tx_shift_empty == 1'b1, "R9 tx disabled no shift", flag_tx_shift_empty, 1);
        @(negedge clk); cfg_tx_en = 1'b1; cfg_rx_en = 1'b0;
        wait_idle();
        chk(cap == 8'h81, "R9 held byte sent", cap, 8'h81);
        chk(flag_rx_full == 1'b0, "R9 rx disabled no capture", flag_rx_full, 0);
        @(negedge clk); cfg_rx_en = 1'b1;
    endtask

    task automatic t_cts();
        @(negedge clk); cfg_hs_off = 1'b0; cfg_hs_rts = 1'b0; cts = 1'b1;
        arm(8'hE7);
        write_byte(8'h4D);
        repeat (60) @(negedge clk);
        chk(flag_tx_buf_empty == 1'b0, "R10 cts blocks load", flag_tx_buf_empty, 0);
        chk(flag_tx_shift_empty == 1'b1, "R10 cts no shift", flag_tx_shift_empty, 1);
        @(negedge clk); cts = 1'b0;
        wait_idle();
        chk(cap == 8'h4D, "R10 sent after cts low", cap, 8'h4D);
        read_byte();
        @(negedge clk); cfg_hs_off = 1'b1;
    endtask

    task automatic t_rts();
        @(negedge clk); cfg_hs_off = 1'b0; cfg_hs_rts = 1'b1;
        @(negedge clk);
        chk(rts == 1'b0, "R11 rts ready", rts, 0);
        arm(8'h33);
        write_byte(8'h44);
        wait_idle();
        chk(rts == 1'b1, "R11 rts full", rts, 1);
        read_byte();
        chk(rts == 1'b0, "R11 rts after read", rts, 0);
        @(negedge clk); cfg_rx_en = 1'b0;
        @(negedge clk);
        chk(rts == 1'b1, "R11 rts rx disabled", rts, 1);
        @(negedge clk); cfg_rx_en = 1'b1; cfg_hs_off = 1'b1;
        @(negedge clk);
        chk(rts == 1'b1, "R11 rts handshake off", rts, 1);
    endtask

    task automatic t_cont();
        @(negedge clk); cfg_tx_en = 1'b0;
        arm(8'h6B);
        @(negedge clk); cfg_cont_rx = 1'b1;
        wait_idle();
        chk(flag_rx_full == 1'b1, "R12 auto receive", flag_rx_full, 1);
        chk(rx_data == 8'h6B, "R12 first byte", rx_data, 8'h6B);
        chk(cap == 8'hFF, "R12 filler ones", cap, 8'hFF);
        arm(8'h92);
        read_byte();
        wait_idle();
        chk(rx_data == 8'h92, "R12 second byte", rx_data, 8'h92);
        @(negedge clk); cfg_cont_rx = 1'b0;
        read_byte();
        repeat (60) @(negedge clk);
        chk(flag_tx_shift_empty == 1'b1, "R12 stops when off", flag_tx_shift_empty, 1);
        @(negedge clk); cfg_tx_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_prescaler();
        t_modes();
        t_irq();
        t_enables();
        t_cts();
        t_rts();
        t_cont();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule